// File: doc/BRIEF.md
# Multicart Hotspot Bank Mapper

This block sits between a cartridge slot and a 512K flash in a multicart. Each clock cycle is one bus cycle. The block turns the 13-bit cartridge address into a 19-bit flash address. Address bit 12 is the cartridge select. The mapping depends on the game that the menu launched.

Plain images of 1K, 2K or 4K are mirrored across the 4K window. Banked images of 8K, 16K or 32K change their active 4K bank when the CPU touches a hotspot address near the top of the window. The switch happens on any bus cycle, reads, writes and dummy fetches alike. The banked modes can also enable a 128-byte RAM. That RAM has separate write and read address windows, and flash output is held off in both.

Every game sits in a slot of its own, so many images share one flash. At reset the menu image is mapped from the last 4K of flash. A menu launch latches the mode, slot and RAM option. A pushbutton forces bank 0 and arms a detector. The next bus cycle at address 0x0801 then returns the mapping to the menu image.

Top module: `cart_mapper`

## Requirements
- R1: After reset, and again after a return to the menu, the flash address is 0x7F000 plus A[11:0]. Hotspots have no effect and the RAM is off.
- R2: `launch_i` latches `mode_i`, `slot_i` and `ram_en_i`. Mode codes: 0=1K, 1=2K, 2=4K, 3=8K two-bank, 4=16K four-bank, 5=32K eight-bank. A plain image (codes 0 to 2) uses A[9:0], A[10:0] or A[11:0] of the offset and mirrors the rest.
- R3: In the two-bank mode, any bus cycle at address 0x1FF8 selects bank 0 and any bus cycle at 0x1FF9 selects bank 1. Reads and writes both count. The new bank applies from the next bus cycle. An address with bit 12 low never switches the bank.
- R4: In the four-bank mode, addresses 0x1FF6 to 0x1FF9 select banks 0 to 3. Other addresses, such as 0x1FFA, leave the bank unchanged.
- R5: In the eight-bank mode, addresses 0x1FF4 to 0x1FFB select banks 0 to 7.
- R6: A launch into any banked mode starts in that mode's highest bank.
- R7: The flash address is the slot times the image size, plus the bank times 4K, plus the offset, kept to 19 bits. Slot sizes are 4K for plain images and 8K, 16K or 32K for the banked modes, so the slot index wraps at 128, 64, 32 or 16.
- R8: When the RAM option is on in a banked mode, offsets 0x000 to 0x07F (with bit 12 high) raise `ram_we_o` and offsets 0x080 to 0x0FF raise `ram_oe_o`. `flash_oe_o` stays low in both windows, and at most one of the two RAM strobes is high. When the option is off, these addresses read flash.
- R9: `flash_oe_o` is high only on a read cycle (`rw_i`=1) with bit 12 high that is outside a RAM window.
- R10: A cycle with `menu_btn_i` high sets the bank to 0 and arms a return to the menu. Hotspots keep working while armed.
- R11: While armed, a bus cycle at address 0x0801 switches to the menu image from the next cycle. Without arming, 0x0801 has no effect.
- R12: An RTS-like sequence, with an opcode read at 0x1FF8, two dummy reads at 0x1FF9 and then stack reads, leaves the two-bank mode in bank 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus cycle clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 13 | Cartridge address; bit 12 is the cartridge select |
| rw_i | input | 1 | 1 = read cycle, 0 = write cycle |
| mode_i | input | 3 | Image mode code from the menu |
| slot_i | input | 7 | Slot index from the menu |
| ram_en_i | input | 1 | Enables the 128-byte RAM option |
| launch_i | input | 1 | Latches the mode, slot and RAM option and leaves the menu |
| menu_btn_i | input | 1 | Back-to-menu pushbutton, synchronous |
| flash_addr_o | output | 19 | Flash byte address |
| flash_oe_o | output | 1 | Flash output enable |
| ram_we_o | output | 1 | RAM write strobe |
| ram_oe_o | output | 1 | RAM read enable |
| ram_addr_o | output | 7 | RAM byte address |

## Verification
The flash address, flash enable and RAM strobes are combinational from the address on the bus. They are due in the same cycle as the access, under the bank latched at the end of the previous cycle. A hotspot, button or 0x0801 access therefore shows its effect only on the cycle after it. The driver applies each access at a falling edge and queues the expected outputs. The monitor compares them one time unit later, inside that same cycle, so every check that follows a switch is a separate later access.

// File: rtl/cart_pkg.sv
package cart_pkg;
  localparam logic [2:0] MODE_1K = 3'd0;
  localparam logic [2:0] MODE_2K = 3'd1;
  localparam logic [2:0] MODE_4K = 3'd2;
  localparam logic [2:0] MODE_B2 = 3'd3;
  localparam logic [2:0] MODE_B4 = 3'd4;
  localparam logic [2:0] MODE_B8 = 3'd5;

  function automatic logic [3:0] bank_count(input logic [2:0] m);
    case (m)
      MODE_B2: return 4'd2;
      MODE_B4: return 4'd4;
      MODE_B8: return 4'd8;
      default: return 4'd1;
    endcase
  endfunction

  function automatic logic [3:0] image_shift(input logic [2:0] m);
    case (m)
      MODE_B2: return 4'd13;
      MODE_B4: return 4'd14;
      MODE_B8: return 4'd15;
      default: return 4'd12;
    endcase
  endfunction

  function automatic logic is_banked(input logic [2:0] m);
    return (m == MODE_B2) || (m == MODE_B4) || (m == MODE_B8);
  endfunction
endpackage

// File: rtl/cart_hotspot.sv
module cart_hotspot
  import cart_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        mode_i,
  output logic              hit_o,
  output logic [BANK_W-1:0] idx_o
);
  localparam int OFF_W = ADDR_W - 1;

  logic [OFF_W-1:0] off, base, diff;
  logic [3:0]       cnt;

  assign off = addr_i[OFF_W-1:0];
  assign cnt = bank_count(mode_i);

  // hotspots sit just below the top of the window, one per bank
  always_comb begin
    base = '1;
    case (mode_i)
      MODE_B2: base = OFF_W'(12'hFF8);
      MODE_B4: base = OFF_W'(12'hFF6);
      MODE_B8: base = OFF_W'(12'hFF4);
      default: base = '1;
    endcase
  end

  assign diff  = off - base;
  assign hit_o = addr_i[ADDR_W-1] && is_banked(mode_i) && (off >= base)
                 && (diff < OFF_W'(cnt));
  assign idx_o = diff[BANK_W-1:0];
endmodule

// File: rtl/cart_bank_ctl.sv
module cart_bank_ctl
  import cart_pkg::*;
#(
  parameter int              ADDR_W   = 13,
  parameter int              BANK_W   = 3,
  parameter int              SLOT_W   = 7,
  parameter logic [ADDR_W-1:0] MENU_KEY = 13'h0801
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        mode_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              ram_en_i,
  input  logic              launch_i,
  input  logic              menu_btn_i,
  input  logic              hs_hit_i,
  input  logic [BANK_W-1:0] hs_idx_i,
  output logic [2:0]        mode_q,
  output logic [SLOT_W-1:0] slot_q,
  output logic              ram_q,
  output logic [BANK_W-1:0] bank_q,
  output logic              menu_q,
  output logic              armed_q
);
  logic [3:0] top_cnt;
  assign top_cnt = bank_count(mode_i) - 4'd1;

  // priority: launch, button, menu key, hotspot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_4K;
      slot_q  <= '0;
      ram_q   <= 1'b0;
      bank_q  <= '0;
      menu_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (launch_i) begin
      mode_q  <= mode_i;
      slot_q  <= slot_i;
      ram_q   <= ram_en_i && is_banked(mode_i);
      bank_q  <= top_cnt[BANK_W-1:0];
      menu_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (menu_btn_i) begin
      bank_q  <= '0;
      armed_q <= 1'b1;
    end else if (armed_q && addr_i == MENU_KEY) begin
      bank_q  <= '0;
      menu_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (!menu_q && hs_hit_i) begin
      bank_q  <= hs_idx_i;
    end
  end
endmodule

// File: rtl/cart_addr_map.sv
module cart_addr_map
  import cart_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int FLASH_W = 19,
  parameter int BANK_W  = 3,
  parameter int SLOT_W  = 7,
  parameter int RAM_AW  = 7
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               rw_i,
  input  logic [2:0]         mode_q,
  input  logic [SLOT_W-1:0]  slot_q,
  input  logic               ram_q,
  input  logic [BANK_W-1:0]  bank_q,
  input  logic               menu_q,
  output logic [FLASH_W-1:0] flash_addr_o,
  output logic               flash_oe_o,
  output logic               ram_we_o,
  output logic               ram_oe_o,
  output logic [RAM_AW-1:0]  ram_addr_o
);
  localparam int OFF_W = ADDR_W - 1;
  localparam logic [FLASH_W-1:0] MENU_BASE = ~FLASH_W'((1 << OFF_W) - 1);

  logic              cs;
  logic [OFF_W-1:0]  off, off_m;
  logic [FLASH_W-1:0] slot_base, bank_base;
  logic              ram_hit;

  assign cs  = addr_i[ADDR_W-1];
  assign off = addr_i[OFF_W-1:0];

  always_comb begin
    case (mode_q)
      MODE_1K: off_m = off & OFF_W'(12'h3FF);
      MODE_2K: off_m = off & OFF_W'(12'h7FF);
      default: off_m = off;
    endcase
  end

  assign slot_base = FLASH_W'(slot_q) << image_shift(mode_q);
  assign bank_base = FLASH_W'(bank_q) << OFF_W;

  always_comb begin
    if (menu_q) flash_addr_o = MENU_BASE | FLASH_W'(off);
    else        flash_addr_o = slot_base | bank_base | FLASH_W'(off_m);
  end

  // RAM occupies the lowest 2*2^RAM_AW bytes: write half then read half
  assign ram_hit    = ram_q && !menu_q && cs && (off[OFF_W-1:RAM_AW+1] == '0);
  assign ram_we_o   = ram_hit && !off[RAM_AW];
  assign ram_oe_o   = ram_hit &&  off[RAM_AW];
  assign ram_addr_o = off[RAM_AW-1:0];
  assign flash_oe_o = cs && rw_i && !ram_hit;
endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
  import cart_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int FLASH_W = 19,
  parameter int BANK_W  = 3,
  parameter int RAM_AW  = 7,
  parameter int SLOT_W  = FLASH_W - ADDR_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               rw_i,
  input  logic [2:0]         mode_i,
  input  logic [SLOT_W-1:0]  slot_i,
  input  logic               ram_en_i,
  input  logic               launch_i,
  input  logic               menu_btn_i,
  output logic [FLASH_W-1:0] flash_addr_o,
  output logic               flash_oe_o,
  output logic               ram_we_o,
  output logic               ram_oe_o,
  output logic [RAM_AW-1:0]  ram_addr_o
);
  logic [2:0]        mode_q;
  logic [SLOT_W-1:0] slot_q;
  logic              ram_q, menu_q, armed_q, hs_hit;
  logic [BANK_W-1:0] bank_q, hs_idx;

  cart_hotspot #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_hs (
    .addr_i (addr_i),
    .mode_i (mode_q),
    .hit_o  (hs_hit),
    .idx_o  (hs_idx)
  );

  cart_bank_ctl #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .SLOT_W(SLOT_W)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .mode_i     (mode_i),
    .slot_i     (slot_i),
    .ram_en_i   (ram_en_i),
    .launch_i   (launch_i),
    .menu_btn_i (menu_btn_i),
    .hs_hit_i   (hs_hit),
    .hs_idx_i   (hs_idx),
    .mode_q     (mode_q),
    .slot_q     (slot_q),
    .ram_q      (ram_q),
    .bank_q     (bank_q),
    .menu_q     (menu_q),
    .armed_q    (armed_q)
  );

  cart_addr_map #(.ADDR_W(ADDR_W), .FLASH_W(FLASH_W), .BANK_W(BANK_W),
                  .SLOT_W(SLOT_W), .RAM_AW(RAM_AW)) u_map (
    .addr_i       (addr_i),
    .rw_i         (rw_i),
    .mode_q       (mode_q),
    .slot_q       (slot_q),
    .ram_q        (ram_q),
    .bank_q       (bank_q),
    .menu_q       (menu_q),
    .flash_addr_o (flash_addr_o),
    .flash_oe_o   (flash_oe_o),
    .ram_we_o     (ram_we_o),
    .ram_oe_o     (ram_oe_o),
    .ram_addr_o   (ram_addr_o)
  );
endmodule

// File: rtl/cart_mapper_chk.sv
module cart_mapper_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [12:0] addr_i,
  input logic        rw_i,
  input logic [2:0]  mode_i,
  input logic        launch_i,
  input logic        menu_btn_i,
  input logic [18:0] flash_addr_o,
  input logic        flash_oe_o,
  input logic        ram_we_o,
  input logic        ram_oe_o,
  input logic [2:0]  mode_q,
  input logic [2:0]  bank_q,
  input logic        menu_q,
  input logic        armed_q
);
  assert_no_bus_fight_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flash_oe_o && (ram_we_o || ram_oe_o)));

  assert_ram_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ram_we_o, ram_oe_o}));

  assert_write_no_oe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rw_i |-> !flash_oe_o);

  assert_b2_hotspot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!menu_q && mode_q == 3'd3 && addr_i == 13'h1FF9 && !launch_i && !menu_btn_i)
    |=> bank_q == 3'd1);

  assert_launch_top_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_i && mode_i == 3'd3) |=> (bank_q == 3'd1 && !menu_q));

  assert_btn_bank0_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (menu_btn_i && !launch_i) |=> (bank_q == 3'd0 && armed_q));

  assert_menu_key_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && addr_i == 13'h0801 && !launch_i && !menu_btn_i) |=> menu_q);

  assert_menu_map_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    menu_q |-> (flash_addr_o[18:12] == 7'h7F && !ram_we_o && !ram_oe_o));
endmodule

bind cart_mapper cart_mapper_chk u_chk (.*);

// File: tb/tb_cart_mapper.sv
`timescale 1ns/1ps
module tb_cart_mapper;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [12:0] addr = '0;
  logic        rw = 1'b1;
  logic [2:0]  mode = '0;
  logic [6:0]  slot = '0;
  logic        ram_en = 1'b0, launch = 1'b0, btn = 1'b0;
  logic [18:0] flash_addr;
  logic        flash_oe, ram_we, ram_oe;
  logic [6:0]  ram_addr;

  int compared = 0, mismatched = 0;
  bit done = 0;

  typedef struct {
    logic [18:0] a;
    logic        oe, we, re;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  cart_mapper dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .rw_i(rw), .mode_i(mode),
    .slot_i(slot), .ram_en_i(ram_en), .launch_i(launch), .menu_btn_i(btn),
    .flash_addr_o(flash_addr), .flash_oe_o(flash_oe), .ram_we_o(ram_we),
    .ram_oe_o(ram_oe), .ram_addr_o(ram_addr)
  );

  // one bus cycle; outputs are combinational and due in this same cycle
  task automatic acc(input logic [12:0] a, input logic r, input logic [18:0] ea,
                     input logic eoe, input logic ewe, input logic ere, input string tag);
    exp_t e;
    @(negedge clk);
    addr = a; rw = r;
    e.a = ea; e.oe = eoe; e.we = ewe; e.re = ere; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic rd(input logic [12:0] a, input logic [18:0] ea, input string tag);
    acc(a, 1'b1, ea, a[12], 1'b0, 1'b0, tag);
  endtask

  task automatic do_launch(input logic [2:0] m, input logic [6:0] s, input logic r);
    @(negedge clk);
    launch = 1'b1; mode = m; slot = s; ram_en = r; addr = '0; rw = 1'b1;
    @(negedge clk);
    launch = 1'b0;
  endtask

  task automatic press;
    @(negedge clk);
    btn = 1'b1; addr = '0; rw = 1'b1;
    @(negedge clk);
    btn = 1'b0;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        compared++;
        if (flash_addr !== e.a || flash_oe !== e.oe || ram_we !== e.we || ram_oe !== e.re) begin
          mismatched++;
          $display("FAIL %s: got addr=%h oe=%b we=%b re=%b, expected addr=%h oe=%b we=%b re=%b",
                   e.tag, flash_addr, flash_oe, ram_we, ram_oe, e.a, e.oe, e.we, e.re);
        end
      end
    end
  end

  initial begin : watchdog
    #(5.0 * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stim
    #12 rst_ni = 1'b1;
    // R1 reset state: menu image in last 4K
    rd(13'h1000, 19'h7F000, "R1 reset menu");
    acc(13'h1ABC, 1'b0, 19'h7FABC, 1'b0, 1'b0, 1'b0, "R9 write cycle no oe");
    rd(13'h1005, 19'h7F005, "R1 no ram in menu");
    rd(13'h0123, 19'h7F123, "R9 A12 low no oe");

    // R2 plain images, mirrored
    do_launch(3'd1, 7'd5, 1'b0);
    rd(13'h1F23, 19'h05723, "R2 2K mirror");
    do_launch(3'd0, 7'd3, 1'b0);
    rd(13'h1BFF, 19'h033FF, "R2 1K mirror");
    do_launch(3'd2, 7'd10, 1'b0);
    rd(13'h1ABC, 19'h0AABC, "R2 4K");

    // R3/R6 two-bank, slot 2 -> base 0x4000
    do_launch(3'd3, 7'd2, 1'b0);
    rd(13'h1000, 19'h05000, "R6 two-bank starts bank 1");
    rd(13'h1FF8, 19'h05FF8, "R3 hotspot cycle uses old bank");
    rd(13'h1100, 19'h04100, "R3 bank 0 after 0x1FF8");
    acc(13'h1FF9, 1'b0, 19'h04FF9, 1'b0, 1'b0, 1'b0, "R3 write to hotspot");
    rd(13'h1100, 19'h05100, "R3 write switched to bank 1");
    acc(13'h0FF8, 1'b1, 19'h05FF8, 1'b0, 1'b0, 1'b0, "R3 A12 low");
    rd(13'h1100, 19'h05100, "R3 A12 low no switch");
    rd(13'h1005, 19'h05005, "R8 ram off reads flash");

    // R12 RTS: opcode at 0x1FF8, dummies at 0x1FF9, stack reads
    rd(13'h1FF8, 19'h05FF8, "R12 opcode fetch");
    rd(13'h1FF9, 19'h04FF9, "R12 dummy 1");
    rd(13'h1FF9, 19'h05FF9, "R12 dummy 2");
    rd(13'h01FD, 19'h051FD, "R12 stack lo");
    rd(13'h01FE, 19'h051FE, "R12 stack hi");
    rd(13'h1000, 19'h05000, "R12 final bank 1");

    // R8 RAM option, slot 1 -> base 0x2000, bank 1
    do_launch(3'd3, 7'd1, 1'b1);
    rd(13'h1100, 19'h03100, "R8 flash above ram");
    acc(13'h1005, 1'b1, 19'h03005, 1'b0, 1'b1, 1'b0, "R8 write port");
    acc(13'h1085, 1'b1, 19'h03085, 1'b0, 1'b0, 1'b1, "R8 read port");
    acc(13'h107F, 1'b0, 19'h0307F, 1'b0, 1'b1, 1'b0, "R8 write port top");

    // R4 four-bank, slot 1 -> base 0x4000
    do_launch(3'd4, 7'd1, 1'b0);
    rd(13'h1000, 19'h07000, "R6 four-bank starts bank 3");
    rd(13'h1FF6, 19'h07FF6, "R4 hotspot cycle");
    rd(13'h1000, 19'h04000, "R4 bank 0");
    rd(13'h1FF8, 19'h04FF8, "R4 hotspot cycle");
    rd(13'h1000, 19'h06000, "R4 bank 2");
    rd(13'h1FFA, 19'h06FFA, "R4 non-hotspot");
    rd(13'h1000, 19'h06000, "R4 0x1FFA ignored");
    acc(13'h0801, 1'b1, 19'h06801, 1'b0, 1'b0, 1'b0, "R11 key unarmed");
    rd(13'h1000, 19'h06000, "R11 unarmed key ignored");

    // R5 eight-bank, slot 14 -> base 0x70000
    do_launch(3'd5, 7'd14, 1'b0);
    rd(13'h1000, 19'h77000, "R6 eight-bank starts bank 7");
    rd(13'h1FF4, 19'h77FF4, "R5 hotspot cycle");
    rd(13'h1000, 19'h70000, "R5 bank 0");
    rd(13'h1FFB, 19'h70FFB, "R5 hotspot cycle");
    rd(13'h1000, 19'h77000, "R5 bank 7");
    rd(13'h1FF6, 19'h77FF6, "R5 hotspot cycle");
    rd(13'h1000, 19'h72000, "R5 bank 2");

    // R10/R11 button and return to menu
    press;
    rd(13'h1000, 19'h70000, "R10 button forces bank 0");
    rd(13'h1FF9, 19'h70FF9, "R10 hotspot while armed");
    rd(13'h1000, 19'h75000, "R10 hotspot works armed");
    acc(13'h0801, 1'b1, 19'h75801, 1'b0, 1'b0, 1'b0, "R11 key cycle");
    rd(13'h1000, 19'h7F000, "R11 menu image mapped");
    rd(13'h1FF8, 19'h7FFF8, "R1 menu hotspot cycle");
    rd(13'h1000, 19'h7F000, "R1 menu ignores hotspot");

    // R7 slot wraps at 16 in eight-bank mode: 30 -> 14
    do_launch(3'd5, 7'd30, 1'b0);
    rd(13'h1000, 19'h77000, "R7 slot wrap");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule